// File: doc/BRIEF.md
# Serial Configuration Bitstream Reader

This block is the readout side of a serial configuration memory. It holds a byte array and sends it out one bit per clock to a device that is loading its configuration. The output is a tri-state line, modelled as a data bit and an output-enable. An active-low chip select gates the readout. A combined control input acts as an active-low counter clear and as an active-high output enable.

The address range can be used whole or split into four equal pages. The page is chosen while the clear is held. When the last bit of the active range has gone out, the block releases the data line and pulls its active-low chain output low. In a daisy chain, that output drives the chip select of the next device. A programming-mode input (low means programming) removes the block from the readout path. A power-on timer holds the ready flag low for a fixed number of cycles. A bench-only write port fills the array.

Top module: `cfgrom_reader`

## Requirements
- R1: After `rst` is released, `ready` is low for `POR_CYCLES - 1` rising edges and is high from edge `POR_CYCLES` on. While `ready` is low, `dout_oe` is low and `chain_n` is high.
- R2: On each rising edge where `boot_mode` = 1, `csel_n` = 0 and `clr_n_oe` = 1, one bit is presented on `dout` with `dout_oe` = 1. Bytes go out in ascending address order, and the bits of each byte go out bit 0 first.
- R3: With `page_mode` = 1, the active range runs from `page_idx * DEPTH/4` to `page_idx * DEPTH/4 + DEPTH/4 - 1`. `page_mode` and `page_idx` are sampled on edges where `clr_n_oe` = 0, so changing them later has no effect until the next clear.
- R4: With `page_mode` = 0, `page_idx` is ignored and the active range is addresses 0 to `DEPTH - 1`.
- R5: An edge with `clr_n_oe` = 0 sets the counters back to the start of the range and drives `dout_oe` low, whatever `csel_n` is.
- R6: An edge with `csel_n` = 1 drives `dout_oe` low and holds both counters. Readout resumes at the next bit once `csel_n` is low again.
- R7: One edge after the edge that presents the last bit of the range, `dout_oe` goes low and `chain_n` goes low. The counters do not wrap, and no more data is driven until a clear.
- R8: After the range is exhausted and while `clr_n_oe` stays high, `chain_n` equals `csel_n` as sampled on the previous edge. An edge with `clr_n_oe` = 0 sets `chain_n` high, and it stays high while the range is read again.
- R9: An edge with `boot_mode` = 0 drives `dout_oe` low and `chain_n` high and holds the counters. In this mode `clr_n_oe`, `page_mode` and `page_idx` have no effect.
- R10: `dout` is 0 whenever `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; also the shift clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Bench-only array write strobe |
| wr_addr | input | AW | Bench-only write address |
| wr_data | input | 8 | Bench-only write byte |
| boot_mode | input | 1 | 1 = readout mode, 0 = programming mode |
| csel_n | input | 1 | Active-low chip select |
| clr_n_oe | input | 1 | Low clears the counters; high enables the output |
| page_mode | input | 1 | 1 = four-page addressing |
| page_idx | input | 2 | Page number used when page mode is on |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Data output enable (0 = released) |
| chain_n | output | 1 | Active-low end-of-range / chain enable |
| ready | output | 1 | Power-on sequence complete |

## Verification
Every result is registered, so each one is due one rising edge after the inputs that cause it. The bench drives inputs on the falling edge, waits for one rising edge and samples on the next falling edge. A bit presented at edge n is therefore checked half a cycle later. The end of the range is checked one edge after the last bit, and `ready` is counted edge by edge from the release of reset. Resume points after a pause, a clear or a spell in programming mode are predicted from the bit count the bench keeps itself.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  // Range selection captured while the counters are cleared
  typedef struct packed {
    logic       paged;
    logic [1:0] idx;
  } page_cfg_t;
endpackage

// File: rtl/cfgrom_mem.sv
module cfgrom_mem
  import cfgrom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] store [DEPTH];

  // Single write port plus registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cfgrom_por.sv
module cfgrom_por #(
  parameter int POR_CYCLES = 8,
  localparam int CW = $clog2(POR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt_q == CW'(POR_CYCLES - 1)) ready <= 1'b1;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfgrom_seq.sv
module cfgrom_seq
  import cfgrom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              boot_mode,
  input  logic              csel_n,
  input  logic              clr_n_oe,
  input  logic              page_mode,
  input  logic [1:0]        page_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [AW-1:0]     addr_nxt,
  output logic              dout,
  output logic              dout_oe,
  output logic              chain_n
);
  logic [AW-1:0]    addr_q;
  logic [BIT_W-1:0] bit_q, bit_nxt;
  logic             done_q, done_nxt;
  page_cfg_t        pg_q, pg_nxt, pg_live;
  logic             clear, shifting;

  function automatic logic [AW-1:0] range_lo(page_cfg_t c);
    return c.paged ? {c.idx, {(AW-2){1'b0}}} : '0;
  endfunction

  function automatic logic [AW-1:0] range_hi(page_cfg_t c);
    return c.paged ? {c.idx, {(AW-2){1'b1}}} : '1;
  endfunction

  // Programming mode hides the page inputs
  always_comb begin
    pg_live       = '0;
    pg_live.paged = boot_mode & page_mode;
    pg_live.idx   = boot_mode ? page_idx : 2'b00;
  end

  assign clear    = !ready || (boot_mode && !clr_n_oe);
  assign shifting = ready && boot_mode && !csel_n && clr_n_oe && !done_q;

  always_comb begin
    addr_nxt = addr_q;
    bit_nxt  = bit_q;
    done_nxt = done_q;
    pg_nxt   = pg_q;
    if (clear) begin
      pg_nxt   = pg_live;
      addr_nxt = range_lo(pg_live);
      bit_nxt  = '0;
      done_nxt = 1'b0;
    end else if (shifting) begin
      bit_nxt = bit_q + 1'b1;
      if (bit_q == BIT_W'(BYTE_W - 1)) begin
        if (addr_q == range_hi(pg_q)) done_nxt = 1'b1;
        else                          addr_nxt = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
      pg_q   <= '0;
    end else begin
      addr_q <= addr_nxt;
      bit_q  <= bit_nxt;
      done_q <= done_nxt;
      pg_q   <= pg_nxt;
    end
  end

  // Registered line outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      chain_n <= 1'b1;
    end else if (shifting) begin
      dout    <= rd_byte[bit_q];
      dout_oe <= 1'b1;
      chain_n <= 1'b1;
    end else begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      chain_n <= (ready && boot_mode && clr_n_oe && done_q) ? csel_n : 1'b1;
    end
  end
endmodule

// File: rtl/cfgrom_reader.sv
module cfgrom_reader
  import cfgrom_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int POR_CYCLES = 8,
  parameter int AW         = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              boot_mode,
  input  logic              csel_n,
  input  logic              clr_n_oe,
  input  logic              page_mode,
  input  logic [1:0]        page_idx,
  output logic              dout,
  output logic              dout_oe,
  output logic              chain_n,
  output logic              ready
);
  logic [AW-1:0]     addr_nxt;
  logic [BYTE_W-1:0] rd_byte;

  cfgrom_por #(.POR_CYCLES(POR_CYCLES)) i_por (
    .clk(clk), .rst(rst), .ready(ready)
  );

  cfgrom_mem #(.DEPTH(DEPTH), .AW(AW)) i_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(addr_nxt), .rdata(rd_byte)
  );

  cfgrom_seq #(.DEPTH(DEPTH), .AW(AW)) i_seq (
    .clk(clk), .rst(rst), .ready(ready), .boot_mode(boot_mode),
    .csel_n(csel_n), .clr_n_oe(clr_n_oe), .page_mode(page_mode),
    .page_idx(page_idx), .rd_byte(rd_byte), .addr_nxt(addr_nxt),
    .dout(dout), .dout_oe(dout_oe), .chain_n(chain_n)
  );
endmodule

// File: rtl/cfgrom_reader_chk.sv
module cfgrom_reader_chk (
  input logic clk,
  input logic rst,
  input logic boot_mode,
  input logic csel_n,
  input logic clr_n_oe,
  input logic dout,
  input logic dout_oe,
  input logic chain_n,
  input logic ready
);
  p_por_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (!dout_oe && chain_n));

  p_ready_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  p_clear_tristate_r5: assert property (@(posedge clk) disable iff (rst)
    (boot_mode && !clr_n_oe) |=> !dout_oe);

  p_desel_tristate_r6: assert property (@(posedge clk) disable iff (rst)
    csel_n |=> !dout_oe);

  p_chain_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !chain_n |-> !dout_oe);

  p_clear_chain_high_r8: assert property (@(posedge clk) disable iff (rst)
    (boot_mode && !clr_n_oe) |=> chain_n);

  p_prog_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !boot_mode |=> (!dout_oe && chain_n));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout);
endmodule

bind cfgrom_reader cfgrom_reader_chk i_chk (.*);

// File: tb/test_cfgrom_reader.sv
`timescale 1ns/1ps
module test_cfgrom_reader;
  localparam int DEPTH = 64;
  localparam int POR   = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int QD    = DEPTH / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic boot_mode = 1'b1, csel_n = 1'b1, clr_n_oe = 1'b1, page_mode = 1'b0;
  logic [1:0] page_idx = 2'b00;
  logic dout, dout_oe, chain_n, ready;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfgrom_reader #(.DEPTH(DEPTH), .POR_CYCLES(POR)) i_cfgrom_reader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .boot_mode(boot_mode), .csel_n(csel_n), .clr_n_oe(clr_n_oe),
    .page_mode(page_mode), .page_idx(page_idx),
    .dout(dout), .dout_oe(dout_oe), .chain_n(chain_n), .ready(ready)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 90) ^ (a >> 3));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Clear with the given page setting, then select; first bit is due one edge later
  task automatic start(logic pm, logic [1:0] pi);
    clr_n_oe = 1'b0; page_mode = pm; page_idx = pi; boot_mode = 1'b1;
    tick();
    clr_n_oe = 1'b1; csel_n = 1'b0;
  endtask

  task automatic read_run(string req, int a0, int b0, int nbits);
    int a = a0, b = b0;
    for (int i = 0; i < nbits; i++) begin
      tick();
      chk({req, " oe"}, 32'(dout_oe), 32'd1);
      chk({req, " data"}, 32'(dout), 32'(pat(a)[b]));
      b++;
      if (b == 8) begin b = 0; a++; end
    end
  endtask

  task automatic t_reset();
    for (int a = 0; a < DEPTH; a++) begin
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = pat(a);
      @(negedge clk);
    end
    wr_en = 1'b0;
    chk("R1 ready in reset", 32'(ready), 32'd0);
    chk("R1 oe in reset", 32'(dout_oe), 32'd0);
    chk("R1 chain in reset", 32'(chain_n), 32'd1);
    rst = 1'b0;
    for (int k = 1; k <= POR; k++) begin
      tick();
      if (k == POR - 1) begin
        chk("R1 ready still low", 32'(ready), 32'd0);
        chk("R1 oe during por", 32'(dout_oe), 32'd0);
      end
      if (k == POR) chk("R1 ready high", 32'(ready), 32'd1);
    end
  endtask

  task automatic t_full_range();
    start(1'b0, 2'd3);
    read_run("R2 R4 full range", 0, 0, DEPTH * 8);
    tick();
    chk("R7 oe released", 32'(dout_oe), 32'd0);
    chk("R7 chain low", 32'(chain_n), 32'd0);
    repeat (3) tick();
    chk("R7 no wrap", 32'(dout_oe), 32'd0);
    csel_n = 1'b1; tick();
    chk("R8 chain follows cs high", 32'(chain_n), 32'd1);
    csel_n = 1'b0; tick();
    chk("R8 chain follows cs low", 32'(chain_n), 32'd0);
    clr_n_oe = 1'b0; tick();
    chk("R8 chain high on clear", 32'(chain_n), 32'd1);
    chk("R5 oe on clear", 32'(dout_oe), 32'd0);
    clr_n_oe = 1'b1;
    read_run("R5 restart at 0", 0, 0, 8);
    chk("R8 chain high while rereading", 32'(chain_n), 32'd1);
  endtask

  task automatic t_page(logic [1:0] pi);
    start(1'b1, pi);
    page_idx = ~pi;  // changed after sampling: must not matter
    read_run("R3 page readout", int'(pi) * QD, 0, QD * 8);
    tick();
    chk("R3 page end oe", 32'(dout_oe), 32'd0);
    chk("R3 page end chain", 32'(chain_n), 32'd0);
    csel_n = 1'b1;
  endtask

  task automatic t_pause();
    start(1'b0, 2'd0);
    read_run("R6 before pause", 0, 0, 13);
    csel_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 oe while deselected", 32'(dout_oe), 32'd0);
    end
    csel_n = 1'b0;
    read_run("R6 resume", 1, 5, 10);
  endtask

  task automatic t_clear_mid();
    clr_n_oe = 1'b0; tick();
    chk("R5 oe during clear", 32'(dout_oe), 32'd0);
    clr_n_oe = 1'b1;
    read_run("R5 after clear", 0, 0, 8);
  endtask

  task automatic t_prog();
    start(1'b0, 2'd0);
    read_run("R9 before prog", 0, 0, 5);
    boot_mode = 1'b0; tick();
    chk("R9 oe in prog", 32'(dout_oe), 32'd0);
    chk("R9 chain in prog", 32'(chain_n), 32'd1);
    clr_n_oe = 1'b0; page_mode = 1'b1; page_idx = 2'd2;
    repeat (2) tick();
    chk("R9 oe with clear in prog", 32'(dout_oe), 32'd0);
    clr_n_oe = 1'b1; boot_mode = 1'b1;
    read_run("R9 resume after prog", 0, 5, 12);
    csel_n = 1'b1;
    page_mode = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full_range();
    t_page(2'd1);
    t_page(2'd3);
    t_pause();
    t_clear_mid();
    t_prog();
    tick();
    chk("R10 idle data low", 32'(dout), 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule